// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block manages a bank of up to 32 general-purpose pins. Each pin can belong to the controller or be handed to an on-chip peripheral that shares the pad. A controller-owned pin is either an input that follows the outside world, or an output whose level comes from a stored data bit. A peripheral-owned pin takes both its value and its enable from the peripheral. Any pin can be switched to open-drain driving, so that several devices can share one wire.

Software reaches the block through a simple register port. The port has a write strobe, a read strobe, a shared 4-bit address and a data word; read data is returned one cycle after the read strobe, with a valid pulse. The output data word is never written directly. One address sets bits where ones are written and another clears bits where ones are written, so two agents can change different pins without a read-modify-write sequence. All pin inputs are resynchronised before use. Every synchronised transition sets a sticky change flag, including on pins owned by a peripheral. The flags, masked per line, form a single interrupt.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every line is controller-owned and an input: pin_oe is all zero, irq is 0, and the ownership, direction, output data, open-drain, interrupt-enable and change-status registers all read 0.
- R2: A line whose ownership bit (address 0) is 1 passes per_out to pin_out and per_oe to pin_oe, whatever its direction and output data bits hold.
- R3: A controller-owned line with direction bit (address 1) equal to 0 has pin_oe = 0; with direction 1 and open-drain off, pin_oe = 1 and pin_out equals its output data bit.
- R4: A write to address 2 sets each output data bit whose written bit is 1 and leaves the bits written 0 unchanged; the output data word reads back at address 4.
- R5: A write to address 3 clears each output data bit whose written bit is 1 and leaves the other bits unchanged; output data changes through no other means.
- R6: Address 6 returns the synchronised pin level of every line, whatever owns it and whatever its direction, and per_in carries the same synchronised level.
- R7: Each transition of a synchronised pin level sets that line's sticky bit in the change-status register (address 7), also for peripheral-owned lines; a read of address 7 returns the flags and clears them, but a transition that is detected in the same cycle as that read stays set for the next read.
- R8: irq is 1 exactly when some change-status bit is 1 and its bit in the interrupt-enable register (address 8) is also 1.
- R9: For a line whose open-drain bit (address 5) is 1, a selected value of 1 turns the driver off (pin_oe = 0) and a value of 0 drives low (pin_oe = 1, pin_out = 0), for controller-owned and peripheral-owned lines alike.
- R10: The ownership, direction, open-drain and interrupt-enable registers read back what was written. Addresses 2 and 3 and unused addresses read 0, and writes to the read-only addresses 4, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | One-cycle pulse one clock after reg_rd |
| pin_in | input | NLINES | Asynchronous pad input levels |
| pin_out | output | NLINES | Pad output value |
| pin_oe | output | NLINES | Pad output enable |
| per_out | input | NLINES | Peripheral output value for each line |
| per_oe | input | NLINES | Peripheral output enable for each line |
| per_in | output | NLINES | Synchronised pin level passed to peripherals |
| irq | output | 1 | Masked change interrupt |

## Verification
The bench builds the block with NLINES = 32, SYNC_STAGES = 3 and OPEN_DRAIN = 1. This covers the full register width and the open-drain path. It also uses a synchroniser one stage deeper than the default, so the change-versus-read race is checked at a latency the default build does not have. The race test times a pin toggle so that its detection lands on the same edge as a status read. Open-drain is checked on controller-owned and peripheral-owned lines.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      RA_OWNSEL = 4'h0,
      RA_DIR    = 4'h1,
      RA_SET    = 4'h2,
      RA_CLR    = 4'h3,
      RA_OUT    = 4'h4,
      RA_ODRN   = 4'h5,
      RA_PINS   = 4'h6,
      RA_CHG    = 4'h7,
      RA_IEN    = 4'h8
   } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned NLINES = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] pin_async,
   output logic [NLINES-1:0] level,
   output logic [NLINES-1:0] edge_hit
);
   localparam int unsigned PRIME_MAX = STAGES + 1;
   localparam int unsigned PW        = $clog2(PRIME_MAX + 1);
   localparam logic [PW-1:0] PRIME_END = PW'(PRIME_MAX);

   logic [NLINES-1:0] stage_q [STAGES];
   logic [NLINES-1:0] hist_q;
   logic [PW-1:0]     prime_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
         hist_q  <= '0;
         prime_q <= '0;
      end else begin
         stage_q[0] <= pin_async;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
         hist_q <= stage_q[STAGES-1];
         if (prime_q != PRIME_END) prime_q <= prime_q + 1'b1;
      end
   end

   assign level    = stage_q[STAGES-1];
   assign edge_hit = (prime_q == PRIME_END) ? (level ^ hist_q) : '0;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int unsigned NLINES     = 32,
   parameter bit          OPEN_DRAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [NLINES-1:0] reg_wdata,
   input  logic [NLINES-1:0] level,
   input  logic [NLINES-1:0] edge_hit,
   output logic [NLINES-1:0] sel_q,
   output logic [NLINES-1:0] dir_q,
   output logic [NLINES-1:0] out_q,
   output logic [NLINES-1:0] od_q,
   output logic [NLINES-1:0] reg_rdata,
   output logic              reg_rvalid,
   output logic              irq
);
   logic [NLINES-1:0] ien_q;
   logic [NLINES-1:0] status_q;
   logic [NLINES-1:0] rd_mux;
   logic              wr_set, wr_clr, rd_chg;

   assign wr_set = reg_wr && (reg_addr == RA_SET);
   assign wr_clr = reg_wr && (reg_addr == RA_CLR);
   assign rd_chg = reg_rd && (reg_addr == RA_CHG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         dir_q <= '0;
         ien_q <= '0;
         out_q <= '0;
      end else begin
         if (reg_wr && reg_addr == RA_OWNSEL) sel_q <= reg_wdata;
         if (reg_wr && reg_addr == RA_DIR)    dir_q <= reg_wdata;
         if (reg_wr && reg_addr == RA_IEN)    ien_q <= reg_wdata;
         if (wr_set)      out_q <= out_q | reg_wdata;
         else if (wr_clr) out_q <= out_q & ~reg_wdata;
      end
   end

   generate
      if (OPEN_DRAIN) begin : g_od
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) od_q <= '0;
            else if (reg_wr && reg_addr == RA_ODRN) od_q <= reg_wdata;
         end
      end else begin : g_no_od
         assign od_q = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status_q <= '0;
      else if (rd_chg) status_q <= edge_hit;
      else             status_q <= status_q | edge_hit;
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         RA_OWNSEL: rd_mux = sel_q;
         RA_DIR:    rd_mux = dir_q;
         RA_OUT:    rd_mux = out_q;
         RA_ODRN:   rd_mux = od_q;
         RA_PINS:   rd_mux = level;
         RA_CHG:    rd_mux = status_q;
         RA_IEN:    rd_mux = ien_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd) reg_rdata <= rd_mux;
      end
   end

   assign irq = |(status_q & ien_q);

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((out_q & $past(reg_wdata)) == $past(reg_wdata)))
      else $error("set port missed a bit"); // R4
   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((out_q & ~$past(reg_wdata)) == ($past(out_q) & ~$past(reg_wdata))))
      else $error("set port touched a zero bit"); // R4
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((out_q & $past(reg_wdata)) == '0))
      else $error("clear port missed a bit"); // R5
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(out_q))
      else $error("output data changed without a port write"); // R5
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_chg |=> ((status_q & $past(status_q)) == $past(status_q)))
      else $error("change flag dropped without a read"); // R7
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int unsigned NLINES = 32
) (
   input  logic [NLINES-1:0] sel,
   input  logic [NLINES-1:0] dir,
   input  logic [NLINES-1:0] out_data,
   input  logic [NLINES-1:0] od,
   input  logic [NLINES-1:0] per_out,
   input  logic [NLINES-1:0] per_oe,
   output logic [NLINES-1:0] pin_out,
   output logic [NLINES-1:0] pin_oe
);
   for (genvar i = 0; i < int'(NLINES); i++) begin : g_line
      logic val, en;
      assign val = sel[i] ? per_out[i] : out_data[i];
      assign en  = sel[i] ? per_oe[i]  : dir[i];
      assign pin_oe[i]  = od[i] ? (en & ~val) : en;
      assign pin_out[i] = od[i] ? 1'b0 : val;
   end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
   import gpio_pkg::*;
#(
   parameter int unsigned NLINES      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OPEN_DRAIN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [3:0]        reg_addr,
   input  logic [NLINES-1:0] reg_wdata,
   output logic [NLINES-1:0] reg_rdata,
   output logic              reg_rvalid,
   input  logic [NLINES-1:0] pin_in,
   output logic [NLINES-1:0] pin_out,
   output logic [NLINES-1:0] pin_oe,
   input  logic [NLINES-1:0] per_out,
   input  logic [NLINES-1:0] per_oe,
   output logic [NLINES-1:0] per_in,
   output logic              irq
);
   initial begin
      if (NLINES < 1 || NLINES > 32) $error("NLINES must be 1..32");
      if (SYNC_STAGES < 2)           $error("SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0] level, edge_hit;
   logic [NLINES-1:0] sel_q, dir_q, out_q, od_q;

   gpio_in_sync #(.NLINES(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
      .level(level), .edge_hit(edge_hit));

   gpio_regs #(.NLINES(NLINES), .OPEN_DRAIN(OPEN_DRAIN)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .level(level),
      .edge_hit(edge_hit), .sel_q(sel_q), .dir_q(dir_q), .out_q(out_q),
      .od_q(od_q), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq));

   gpio_pad_mux #(.NLINES(NLINES)) u_mux (
      .sel(sel_q), .dir(dir_q), .out_data(out_q), .od(od_q),
      .per_out(per_out), .per_oe(per_oe),
      .pin_out(pin_out), .pin_oe(pin_oe));

   assign per_in = level;

   AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((~sel_q & ~dir_q & pin_oe) == '0))
      else $error("controller input line is driven"); // R3
   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((od_q & pin_oe & pin_out) == '0))
      else $error("open-drain line drives high"); // R9
   AST_OWNED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_q & ~od_q & (pin_oe ^ per_oe)) == '0))
      else $error("peripheral enable not passed through"); // R2
endmodule

// File: tb/gpio_mux_port_test.sv
module gpio_mux_port_test;
   localparam int unsigned N  = 32;
   localparam int unsigned SS = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [N-1:0]  reg_wdata = '0;
   logic [N-1:0]  reg_rdata;
   logic          reg_rvalid;
   logic [N-1:0]  ext = '0;
   logic [N-1:0]  pin_out, pin_oe, per_in;
   logic [N-1:0]  per_out = '0, per_oe = '0;
   logic          irq;

   int tests = 0, fails = 0;
   logic [N-1:0] exp_q [$];
   string        tag_q [$];

   always #10 clk = ~clk;

   gpio_mux_port #(.NLINES(N), .SYNC_STAGES(SS), .OPEN_DRAIN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .pin_in(ext), .pin_out(pin_out), .pin_oe(pin_oe),
      .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .irq(irq));

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // driver: pushes the expected word, then issues the read
   task automatic rd_expect(input logic [3:0] a, input logic [N-1:0] e, input string tag);
      @(negedge clk);
      exp_q.push_back(e); tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // monitor: pops and compares each returned word
   always @(negedge clk) begin
      if (rst_n && reg_rvalid) begin
         if (exp_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R10 unexpected read data actual=%h expected=none", reg_rdata);
         end else begin
            automatic logic [N-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, reg_rdata, e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", pin_oe, '0);
      check("R1 irq", N'(irq), '0);
      rd_expect(4'h0, '0, "R1 ownership");
      rd_expect(4'h1, '0, "R1 direction");
      rd_expect(4'h4, '0, "R1 out data");
      rd_expect(4'h5, '0, "R1 open-drain");
      rd_expect(4'h8, '0, "R1 int enable");
      rd_expect(4'h7, '0, "R1 change status");

      // R3 / R4 / R5 controller outputs
      wr(4'h1, 32'h0000_00FF);
      wr(4'h2, 32'h0000_00A5);
      check("R3 pin_oe outputs", pin_oe, 32'h0000_00FF);
      check("R3 pin_out value", pin_out & 32'hFF, 32'h0000_00A5);
      rd_expect(4'h4, 32'h0000_00A5, "R4 set");
      wr(4'h2, 32'h0000_000F);
      rd_expect(4'h4, 32'h0000_00AF, "R4 set keeps zeros");
      wr(4'h3, 32'h0000_0003);
      rd_expect(4'h4, 32'h0000_00AC, "R5 clear");
      check("R5 pin_out after clear", pin_out & 32'hFF, 32'h0000_00AC);

      // R2 peripheral ownership
      per_out = 32'h0000_0050; per_oe = 32'h0000_0030;
      wr(4'h0, 32'h0000_00F0);
      check("R2 pin_oe mixed", pin_oe & 32'hFF, 32'h0000_003F);
      check("R2 pin_out mixed", pin_out & 32'hFF, 32'h0000_005C);

      // R9 open drain on controller and peripheral lines
      wr(4'h5, 32'h0000_001F);
      check("R9 od pin_oe", pin_oe & 32'hFF, 32'h0000_0023);
      check("R9 od pin_out", pin_out & 32'hFF, 32'h0000_0040);
      @(negedge clk); per_out = 32'h0000_0040;
      @(negedge clk);
      check("R9 od peripheral low", pin_oe & 32'hFF, 32'h0000_0033);
      check("R9 od pin_out low", pin_out & 32'hFF, 32'h0000_0040);

      // R10 readback and unused addresses
      rd_expect(4'h5, 32'h0000_001F, "R10 open-drain readback");
      rd_expect(4'h0, 32'h0000_00F0, "R10 ownership readback");
      rd_expect(4'h2, '0, "R10 set addr reads zero");
      rd_expect(4'hF, '0, "R10 unused addr");

      // R6 / R7 pin readback and change flags
      @(negedge clk); ext = 32'h1234_5678;
      repeat (8) @(negedge clk);
      rd_expect(4'h6, 32'h1234_5678, "R6 pin levels");
      check("R6 per_in", per_in, 32'h1234_5678);
      rd_expect(4'h7, 32'h1234_5678, "R7 change flags");
      rd_expect(4'h7, '0, "R7 read clears");
      wr(4'h6, 32'hFFFF_FFFF);
      wr(4'h4, 32'hFFFF_FFFF);
      rd_expect(4'h6, 32'h1234_5678, "R10 pins read-only");
      rd_expect(4'h4, 32'h0000_00AC, "R10 out data read-only");

      // R7 peripheral-owned line, R8 masking
      @(negedge clk); ext[5] = ~ext[5];
      repeat (8) @(negedge clk);
      check("R8 masked irq", N'(irq), '0);
      rd_expect(4'h7, 32'h0000_0020, "R7 peripheral line change");
      wr(4'h8, 32'h0000_0200);
      @(negedge clk); ext[9] = ~ext[9];
      repeat (8) @(negedge clk);
      check("R8 irq enabled", N'(irq), 1);
      rd_expect(4'h7, 32'h0000_0200, "R7 enabled line change");
      check("R8 irq after clear", N'(irq), '0);
      @(negedge clk); ext[3] = ~ext[3];
      repeat (8) @(negedge clk);
      check("R8 other line masked", N'(irq), '0);
      rd_expect(4'h7, 32'h0000_0008, "R7 masked line still flagged");

      // R7 race: detection on the same edge as the clearing read
      @(negedge clk); ext[12] = ~ext[12];
      repeat (SS - 1) @(negedge clk);
      rd_expect(4'h7, '0, "R7 race read");
      rd_expect(4'h7, 32'h0000_1000, "R7 race keeps new flag");

      repeat (4) @(negedge clk);
      check("R10 no read left pending", N'(exp_q.size()), '0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule